// File: doc/BRIEF.md
# Serial Master Chip-Select Pin Unit

This block sits beside a queued serial master and owns a small group of pins that
can each serve as a peripheral chip-select or as a plain general-purpose output.
While the queue sequencer reports that a command is running, every pin set up as a
chip-select takes the level that the command's select field gives for it. Because
the field supplies a level rather than an on/off choice, several selects can be
asserted together and each can have its own polarity. Between commands each
chip-select falls back to its base level, which is held in a port data register.
The base level therefore sets the polarity: a low base gives an active-high select
and a high base gives an active-low one.

Pin 0 is shared with the slave-select input. If that input is pulled low while the
unit runs as a master, a sticky mode-fault flag is raised. Until the flag is cleared,
the unit stops driving every pin. Serial shifting and queue sequencing are outside
the block and reach it only as the command-active and select-field inputs.

Top module: `spi_cs_unit`

## Requirements
- R1: After reset the port data register is all zero, no pin is output-enabled and the mode-fault flag is clear.
- R2: In master mode, with no fault, a pin whose assign bit and direction bit are both 1 is driven (pinOe=1) while cmdActive=1, at the level of its own bit of cmdCsBits. Any combination of selects may be asserted at once.
- R3: A chip-select pin in master mode with cmdActive=0 is driven at its port data register bit, so a 0 base gives active-high selects and a 1 base gives active-low ones.
- R4: A pin with direction bit 0 is never driven. A pin with direction 1 and assign 0 is a general-purpose output that always shows its port data bit, whatever the command inputs are.
- R5: A cycle with portWrEn=1 loads portWrData into the port data register. The new base shows on the pins at the same clock edge as the write.
- R6: masterEn=1 with ssInN=0 at a clock edge sets modeFault at that edge. The flag stays set after ssInN returns high.
- R7: In every cycle where modeFault is 1, including the cycle it first rises, pinOe is all zero.
- R8: faultClr=1 clears modeFault at the next edge unless a new fault condition is present in the same cycle. In that case the fault wins and the flag stays set.
- R9: In slave mode (masterEn=0) commands are ignored and chip-select pins show their base. Pin 0 is not driven even when it is set up as a chip-select, and ssInN low raises no fault.
- R10: All pin outputs are registered. A change on any input shows on pinOut, pinOe or modeFault only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterEn | input | 1 | 1 selects master mode, 0 selects slave mode |
| pinAssign | input | NUM_CS | Per pin, 1 gives the pin the chip-select function |
| pinDir | input | NUM_CS | Per pin, 1 makes the pin an output |
| portWrEn | input | 1 | Write strobe for the port data register |
| portWrData | input | NUM_CS | Value to load into the port data register |
| cmdActive | input | 1 | A queue command is executing |
| cmdCsBits | input | NUM_CS | Chip-select levels of the executing command |
| ssInN | input | 1 | Level seen on the shared pin 0 / slave-select input |
| faultClr | input | 1 | Clears the mode-fault flag |
| pinOut | output | NUM_CS | Level driven on each pin |
| pinOe | output | NUM_CS | Output enable of each pin |
| modeFault | output | 1 | Sticky mode-fault flag |

## Verification
A mode-fault detection and a fault clear can occur in the same cycle. So can a fault and a running command that would otherwise drive the selects. The bench raises faultClr while ssInN is still low and expects the flag to stay set. It also lands a fault on a cycle with cmdActive high and expects every output enable to drop at that same edge, not one cycle later. A port-data write that coincides with a running command is also checked: the pins must keep the command levels, and the new base must appear only once the command ends.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef struct packed {
    logic loadPort;   // capture new base levels
    logic selectCmd;  // command levels override the base
    logic haltDrive;  // mode fault: release every pin
    logic slaveMode;  // pin 0 belongs to the slave-select input
  } csStrobes_t;
endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterEn,
  input  logic       portWrEn,
  input  logic       cmdActive,
  input  logic       ssInN,
  input  logic       faultClr,
  output csStrobes_t strobes,
  output logic       modeFault
);
  logic faultFlag;
  logic faultHit;
  logic faultNext;

  // a low slave-select seen while mastering is a conflict on the shared pin
  assign faultHit  = masterEn && !ssInN;
  // a new hit outranks a clear in the same cycle
  assign faultNext = faultHit || (faultFlag && !faultClr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultFlag <= 1'b0;
    else       faultFlag <= faultNext;
  end

  always_comb begin
    strobes.loadPort  = portWrEn;
    strobes.selectCmd = masterEn && cmdActive;
    strobes.haltDrive = faultNext;
    strobes.slaveMode = !masterEn;
  end

  assign modeFault = faultFlag;
endmodule

// File: rtl/spi_cs_datapath.sv
module spi_cs_datapath
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobes_t        strobes,
  input  logic [NUM_CS-1:0] pinAssign,
  input  logic [NUM_CS-1:0] pinDir,
  input  logic [NUM_CS-1:0] portWrData,
  input  logic [NUM_CS-1:0] cmdCsBits,
  output logic [NUM_CS-1:0] pinOut,
  output logic [NUM_CS-1:0] pinOe
);
  localparam int SHARED_PIN = 0;

  logic [NUM_CS-1:0] portReg;
  logic [NUM_CS-1:0] baseNext;
  logic [NUM_CS-1:0] csMode;
  logic [NUM_CS-1:0] outNext;
  logic [NUM_CS-1:0] oeNext;

  assign baseNext = strobes.loadPort ? portWrData : portReg;
  assign csMode   = pinAssign & pinDir;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
    logic sharedHold;
    if (i == SHARED_PIN) begin : g_shared
      assign sharedHold = strobes.slaveMode;
    end else begin : g_plain
      assign sharedHold = 1'b0;
    end

    always_comb begin
      outNext[i] = baseNext[i];
      oeNext[i]  = 1'b0;
      if (csMode[i]) begin
        if (strobes.selectCmd) outNext[i] = cmdCsBits[i];
        oeNext[i] = !sharedHold;
      end else if (pinDir[i]) begin
        oeNext[i] = 1'b1;
      end
      if (strobes.haltDrive) oeNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portReg <= '0;
      pinOut  <= '0;
      pinOe   <= '0;
    end else begin
      portReg <= baseNext;
      pinOut  <= outNext;
      pinOe   <= oeNext;
    end
  end
endmodule

// File: rtl/spi_cs_unit.sv
module spi_cs_unit
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic [NUM_CS-1:0] pinAssign,
  input  logic [NUM_CS-1:0] pinDir,
  input  logic              portWrEn,
  input  logic [NUM_CS-1:0] portWrData,
  input  logic              cmdActive,
  input  logic [NUM_CS-1:0] cmdCsBits,
  input  logic              ssInN,
  input  logic              faultClr,
  output logic [NUM_CS-1:0] pinOut,
  output logic [NUM_CS-1:0] pinOe,
  output logic              modeFault
);
  csStrobes_t strobes;

  spi_cs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterEn  (masterEn),
    .portWrEn  (portWrEn),
    .cmdActive (cmdActive),
    .ssInN     (ssInN),
    .faultClr  (faultClr),
    .strobes   (strobes),
    .modeFault (modeFault)
  );

  spi_cs_datapath #(.NUM_CS(NUM_CS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pinAssign  (pinAssign),
    .pinDir     (pinDir),
    .portWrData (portWrData),
    .cmdCsBits  (cmdCsBits),
    .pinOut     (pinOut),
    .pinOe      (pinOe)
  );
endmodule

// File: rtl/spi_cs_unit_chk.sv
module spi_cs_unit_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic [NUM_CS-1:0] pinAssign,
  input logic [NUM_CS-1:0] pinDir,
  input logic              cmdActive,
  input logic [NUM_CS-1:0] cmdCsBits,
  input logic              ssInN,
  input logic              faultClr,
  input logic [NUM_CS-1:0] pinOut,
  input logic [NUM_CS-1:0] pinOe,
  input logic              modeFault
);
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn && !ssInN) |=> modeFault); // R6
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeFault && !faultClr) |=> modeFault); // R6
  AST_FAULT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (modeFault && faultClr && !(masterEn && !ssInN)) |=> !modeFault); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> (pinOe == '0)); // R7
  AST_SLAVE_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (!modeFault && !(masterEn && !ssInN)) |=> !modeFault); // R9

  for (genvar i = 0; i < NUM_CS; i++) begin : g_pinChk
    AST_CS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      (masterEn && cmdActive && pinAssign[i] && pinDir[i] && ssInN && !modeFault)
      |=> (pinOe[i] && (pinOut[i] == $past(cmdCsBits[i])))); // R2
    AST_INPUT_PIN: assert property (@(posedge clk) disable iff (!rstN)
      !pinDir[i] |=> !pinOe[i]); // R4
  end
endmodule

bind spi_cs_unit spi_cs_unit_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .masterEn  (masterEn),
  .pinAssign (pinAssign),
  .pinDir    (pinDir),
  .cmdActive (cmdActive),
  .cmdCsBits (cmdCsBits),
  .ssInN     (ssInN),
  .faultClr  (faultClr),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .modeFault (modeFault)
);

// File: tb/spi_cs_unit_tb.sv
module spi_cs_unit_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         masterEn = 1'b1;
  logic [N-1:0] pinAssign = '0;
  logic [N-1:0] pinDir = '0;
  logic         portWrEn = 1'b0;
  logic [N-1:0] portWrData = '0;
  logic         cmdActive = 1'b0;
  logic [N-1:0] cmdCsBits = '0;
  logic         ssInN = 1'b1;
  logic         faultClr = 1'b0;
  logic [N-1:0] pinOut;
  logic [N-1:0] pinOe;
  logic         modeFault;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spi_cs_unit #(.NUM_CS(N)) u_dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .pinAssign(pinAssign),
    .pinDir(pinDir), .portWrEn(portWrEn), .portWrData(portWrData),
    .cmdActive(cmdActive), .cmdCsBits(cmdCsBits), .ssInN(ssInN),
    .faultClr(faultClr), .pinOut(pinOut), .pinOe(pinOe), .modeFault(modeFault)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {oe, driven levels} from the pin rules
  function automatic logic [2*N-1:0] expPins(logic [N-1:0] a, logic [N-1:0] d,
      logic act, logic [N-1:0] cmd, logic [N-1:0] base, logic master);
    logic [N-1:0] oe, v;
    for (int i = 0; i < N; i++) begin
      oe[i] = 1'b0; v[i] = 1'b0;
      if (a[i] && d[i]) begin
        oe[i] = !(!master && i == 0);
        v[i]  = (master && act) ? cmd[i] : base[i];
      end else if (d[i]) begin
        oe[i] = 1'b1;
        v[i]  = base[i];
      end
      v[i] = v[i] & oe[i];
    end
    return {oe, v};
  endfunction

  function automatic logic [2*N-1:0] seen();
    return {pinOe, pinOut & pinOe};
  endfunction

  task automatic writeBase(input logic [N-1:0] b);
    portWrEn = 1'b1; portWrData = b;
    @(negedge clk);
    portWrEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] bases [4];
    logic [2*N-1:0] e;
    bases[0] = 4'h0; bases[1] = 4'h9; bases[2] = 4'h6; bases[3] = 4'hF;

    repeat (3) @(negedge clk);
    check(pinOe == 0 && modeFault == 0, "R1 in reset", {pinOe, 3'b0, modeFault}, 0);
    rstN = 1'b1;
    pinDir = 4'hF;
    @(negedge clk);
    // R1: all pins as GPIO outputs show the cleared port register
    check(pinOe == 4'hF && pinOut == 4'h0 && !modeFault, "R1 reset base",
          {pinOe, pinOut}, 8'hF0);

    // R2 R3 R4: sweep every pin configuration, command and base in master mode
    for (int b = 0; b < 4; b++) begin
      pinAssign = '0; pinDir = '0;
      writeBase(bases[b]);
      for (int a = 0; a < 16; a++)
        for (int d = 0; d < 16; d++)
          for (int c = 0; c < 16; c++)
            for (int act = 0; act < 2; act++) begin
              pinAssign = a[N-1:0]; pinDir = d[N-1:0];
              cmdCsBits = c[N-1:0]; cmdActive = act[0];
              @(negedge clk);
              e = expPins(a[N-1:0], d[N-1:0], act[0], c[N-1:0], bases[b], 1'b1);
              check(seen() == e, act ? "R2 sweep" : "R3_R4 sweep", seen(), e);
            end
    end

    // R10: output holds before the edge, follows after it
    pinAssign = 4'hF; pinDir = 4'hF; cmdActive = 1'b0; cmdCsBits = 4'h0;
    writeBase(4'h0);
    @(negedge clk);
    cmdActive = 1'b1; cmdCsBits = 4'hF;
    #1;
    check(pinOut == 4'h0, "R10 before edge", pinOut, 4'h0);
    @(negedge clk);
    check(pinOut == 4'hF, "R10 after edge", pinOut, 4'hF);

    // R5: write during a command keeps command levels, base visible afterward
    cmdCsBits = 4'h3; portWrEn = 1'b1; portWrData = 4'hA;
    @(negedge clk);
    portWrEn = 1'b0;
    check(pinOut == 4'h3, "R5 write under command", pinOut, 4'h3);
    cmdActive = 1'b0;
    @(negedge clk);
    check(pinOut == 4'hA, "R5 new base", pinOut, 4'hA);
    portWrEn = 1'b1; portWrData = 4'h5;
    @(negedge clk);
    portWrEn = 1'b0;
    check(pinOut == 4'h5, "R5 same edge", pinOut, 4'h5);

    // R9: slave mode, commands ignored, pin 0 released, no fault on low select
    masterEn = 1'b0; cmdActive = 1'b1; cmdCsBits = 4'hA; ssInN = 1'b0;
    @(negedge clk);
    e = expPins(4'hF, 4'hF, 1'b1, 4'hA, 4'h5, 1'b0);
    check(seen() == e, "R9 slave pins", seen(), e);
    check(!modeFault, "R9 no slave fault", modeFault, 0);
    ssInN = 1'b1; masterEn = 1'b1;
    @(negedge clk);
    check(pinOe == 4'hF && pinOut == 4'hA, "R2 back to master", {pinOe, pinOut}, 8'hFA);

    // R6 R7: fault lands with a running command; enables drop at once
    ssInN = 1'b0;
    @(negedge clk);
    check(modeFault, "R6 fault set", modeFault, 1);
    check(pinOe == 4'h0, "R7 released on fault edge", pinOe, 0);
    ssInN = 1'b1;
    repeat (3) @(negedge clk);
    check(modeFault && pinOe == 0, "R6 R7 sticky", {pinOe, 3'b0, modeFault}, 1);

    // R8: clear together with a fresh hit loses, plain clear wins
    faultClr = 1'b1; ssInN = 1'b0;
    @(negedge clk);
    check(modeFault, "R8 hit beats clear", modeFault, 1);
    ssInN = 1'b1;
    @(negedge clk);
    faultClr = 1'b0;
    check(!modeFault && pinOe == 4'hF, "R8 cleared", {pinOe, 3'b0, modeFault}, 8'hF0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule